// File: doc/BRIEF.md
# Windowed Carry-Less 32x32 Multiplier

This block multiplies two 32-bit polynomials over GF(2) and returns the 64-bit carry-less product as a low word and a high word. Partial products are combined with XOR, so no carries propagate. The block does not reduce the result modulo any field polynomial.

The block clears the two top bits of operand A and builds a table from the result. The table has eight entries, each an XOR combination of that masked operand shifted by zero, one or two places. The block then walks operand B three bits at a time, one group per cycle. Each group selects a table entry, and the block XORs that entry, shifted to the group's position, into a 64-bit accumulator. The two top bits of A that were cleared are restored by XORing in shifted copies of B. These two corrections are applied while the table is being built.

A caller raises `start_valid` while `start_ready` is high. One cycle later the block builds the table. Eleven cycles after that, the block finishes the groups and pulses `done` for one cycle. The product outputs then hold their value until the next operation changes them.

Top module: `clmul_win32`

## Requirements
- R1: One cycle after `done` is high, {`prod_hi`,`prod_lo`} equals the carry-less product of the accepted A and B: the XOR over every set bit i of A of B shifted left by i.
- R2: The table is built from A with bits 31 and 30 cleared. The 3-bit groups of B start at bit 0 and step by 3. The last group starts at bit 30 and has only two bits. A with only low bits set, and B values that fill every group, give the exact product.
- R3: If bit 30 of A is set, B shifted left by 30 is XORed into the product. This puts B<<30 into the low word and B>>2 into the high word.
- R4: If bit 31 of A is set, B shifted left by 31 is XORed into the product. This puts B<<31 into the low word and B>>1 into the high word.
- R5: `done` is high for exactly one cycle. It rises on the 12th rising edge after the edge that accepted the start: one edge builds the table and eleven edges process the groups.
- R6: `start_ready` is low from the edge after acceptance until `done`. While `start_ready` is low, `start_valid`, `a_in` and `b_in` have no effect on the result.
- R7: While the block is idle, `prod_lo` and `prod_hi` keep their last value.
- R8: After reset, `start_ready` is 1, `done` is 0, and both product words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_valid | input | 1 | Request to start a multiply |
| start_ready | output | 1 | Block is idle and accepts a start |
| a_in | input | 32 | Operand A, sampled on acceptance |
| b_in | input | 32 | Operand B, sampled on acceptance |
| done | output | 1 | One-cycle pulse: product is ready |
| prod_lo | output | 32 | Product bits 31..0 |
| prod_hi | output | 32 | Product bits 63..32 |

## Verification
The assertions assume that a start is presented only through the valid/ready handshake. They also assume that reset is held long enough for the first clock edge to see it. The stability check assumes that no start is accepted in the cycle it looks at.

The bench raises `start_valid` only at the negative clock edge and releases it in the next cycle. While the block is busy, the bench drives random values on `start_valid`, `a_in` and `b_in`. This exercises R6 without breaking the handshake assumptions.

// File: rtl/clmul_win32.sv
module clmul_win32 #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_valid,
  output logic         start_ready,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic         done,
  output logic [W-1:0] prod_lo,
  output logic [W-1:0] prod_hi
);
  localparam int GRP = 3;
  localparam int NTAB = 1 << GRP;
  localparam int NG = (W + GRP - 1) / GRP;
  localparam int GW = $clog2(NG);
  localparam int SW = $clog2(2 * W);

  typedef enum logic [1:0] {IDLE, BUILD, RUN} st_t;

  st_t               st;
  logic [W-1:0]      a_q, b_q;
  logic [W-1:0]      tab [NTAB];
  logic [GW-1:0]     grp;
  logic [2*W-1:0]    acc;
  logic              done_q;

  wire [W-1:0]    a_m   = {2'b00, a_q[W-3:0]};
  wire [SW-1:0]   shamt = SW'(grp) * SW'(GRP);
  wire [W-1:0]    b_sh  = b_q >> shamt;
  wire [GRP-1:0]  idx   = b_sh[GRP-1:0];
  wire [2*W-1:0]  term  = {{W{1'b0}}, tab[idx]} << shamt;
  wire [2*W-1:0]  b_w   = {{W{1'b0}}, b_q};
  wire [2*W-1:0]  fix   = (a_q[W-2] ? (b_w << (W-2)) : '0)
                        ^ (a_q[W-1] ? (b_w << (W-1)) : '0);

  assign start_ready = (st == IDLE);
  assign done        = done_q;
  assign prod_lo     = acc[W-1:0];
  assign prod_hi     = acc[2*W-1:W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= IDLE;
      a_q    <= '0;
      b_q    <= '0;
      grp    <= '0;
      acc    <= '0;
      done_q <= 1'b0;
      for (int k = 0; k < NTAB; k++) tab[k] <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        IDLE: if (start_valid) begin
          a_q <= a_in;
          b_q <= b_in;
          st  <= BUILD;
        end
        BUILD: begin
          for (int k = 0; k < NTAB; k++)
            tab[k] <= (k[0] ? a_m : '0) ^ (k[1] ? (a_m << 1) : '0)
                    ^ (k[2] ? (a_m << 2) : '0);
          acc <= fix;
          grp <= '0;
          st  <= RUN;
        end
        RUN: begin
          acc <= acc ^ term;
          grp <= grp + 1'b1;
          if (grp == GW'(NG - 1)) begin
            st     <= IDLE;
            done_q <= 1'b1;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/clmul_win32_chk.sv
module clmul_win32_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_valid,
  input logic         start_ready,
  input logic         done,
  input logic [W-1:0] prod_lo,
  input logic [W-1:0] prod_hi
);
  localparam int LAT = 12;
  logic [4:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (start_valid && start_ready) cnt <= 5'd1;
    else if (done) cnt <= '0;
    else if (cnt != 0) cnt <= cnt + 5'd1;
  end

  a_r5_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cnt == 5'(LAT + 1)));
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready) |=> !start_ready);
  a_r6_ready_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> start_ready);
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ready && !start_valid) |=> ($stable(prod_lo) && $stable(prod_hi)));
endmodule

bind clmul_win32 clmul_win32_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
  .done(done), .prod_lo(prod_lo), .prod_hi(prod_hi)
);

// File: tb/tb_clmul_win32.sv
module tb_clmul_win32;
  logic clk = 0, rst_n = 0, start_valid = 0;
  logic [31:0] a_in = 0, b_in = 0;
  logic start_ready, done;
  logic [31:0] prod_lo, prod_hi;
  int errors = 0, checks = 0, cyc = 0;
  bit finished = 0;

  typedef struct { logic [63:0] exp; int acc_cyc; string tag; } item_t;
  item_t q[$];
  logic [63:0] last_exp;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  clmul_win32 dut (.*);

  function automatic logic [63:0] ref_mul(logic [31:0] a, logic [31:0] b);
    logic [63:0] r = '0;
    for (int i = 0; i < 32; i++) if (a[i]) r ^= {32'b0, b} << i;
    return r;
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(logic [31:0] a, logic [31:0] b, string tag);
    item_t it;
    @(negedge clk);
    while (!start_ready) @(negedge clk);
    start_valid = 1; a_in = a; b_in = b;
    it.exp = ref_mul(a, b); it.acc_cyc = cyc + 1; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    // R6: noise on the inputs while the block is busy
    start_valid = $urandom_range(0, 1); a_in = $urandom; b_in = $urandom;
    while (!start_ready) begin
      @(negedge clk);
      start_valid = $urandom_range(0, 1); a_in = $urandom; b_in = $urandom;
    end
    start_valid = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      item_t it;
      if (q.size() == 0) chk(0, "R5 unexpected done", 0, 0);
      else begin
        it = q.pop_front();
        chk({prod_hi, prod_lo} == it.exp, it.tag, {prod_hi, prod_lo}, it.exp);
        chk(cyc == it.acc_cyc + 12, "R5 latency", 64'(cyc - it.acc_cyc), 64'd12);
        last_exp = it.exp;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(start_ready === 1 && done === 0, "R8 reset ctrl", {start_ready, done}, 2'b10);
    chk({prod_hi, prod_lo} === 64'd0, "R8 reset product", {prod_hi, prod_lo}, 0);
    rst_n = 1;
    run_op(32'h0, 32'hFFFF_FFFF, "R1 A zero");
    run_op(32'hFFFF_FFFF, 32'h0, "R1 B zero");
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1 all ones");
    run_op(32'h4000_0000, 32'hDEAD_BEEF, "R3 bit30 only");
    run_op(32'h8000_0000, 32'hDEAD_BEEF, "R4 bit31 only");
    run_op(32'hC000_0001, 32'h8000_0001, "R3 R4 both top bits");
    run_op(32'h3FFF_FFFF, 32'hC000_0007, "R2 masked A, edge groups");
    run_op(32'h0000_0001, 32'h1234_5678, "R2 identity");
    run_op(32'h0000_0007, 32'hFFFF_FFFF, "R2 full groups");
    for (int i = 0; i < 40; i++) run_op($urandom, $urandom, "R1 random");
    repeat (3) @(negedge clk);
    // R7: outputs hold while idle
    chk({prod_hi, prod_lo} == last_exp, "R7 hold", {prod_hi, prod_lo}, last_exp);
    chk(q.size() == 0, "R5 missing done", 64'(q.size()), 0);
    finished = 1;
  end

  initial begin
    int wd = 0;
    while (!finished && wd < 100000) begin @(posedge clk); wd++; end
    if (!finished) chk(0, "watchdog", 64'(wd), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule